// File: doc/BRIEF.md
# Shared Timer Clock Prescaler with Synchronized Release

This block produces count-enable strobes for two timer/counters from one shared prescaler. A free-running 10-bit counter on the system clock supplies divided tap rates. Each timer chooses a tap, the undivided clock, or an edge of its own external clock pin through a 3-bit select. External pins pass through a two-stage synchronizer and an edge-detect register, and they are never divided.

A small control register holds three bits. The synchronization bit makes the prescaler-reset bit sticky. Software can therefore halt both timers, load matching counts into them, and release them together by clearing the synchronization bit. With the synchronization bit clear, writing the reset bit restarts the prescaler for a single cycle. A capture-source select bit is stored and presented for the capture logic.

Top module: `shared_prescaler`

## Requirements
- R1: After reset the register reads 0x00, `halted` is 0, and `cap_src` is 0.
- R2: Register layout: bit 7 is the synchronization bit, bit 6 is the capture-source select, and bit 0 is the prescaler-reset bit. Bits 5 to 1 always read 0, whatever is written to them.
- R3: With the synchronization bit 0, writing 1 to bit 0 sets `halted` for exactly one cycle, after which the bit clears itself. The prescaler counter then restarts from zero.
- R4: While the synchronization bit is 1, the reset bit keeps its written value between writes, so `halted` stays at that value.
- R5: While `halted` is 1, `ce0` and `ce1` are both 0 for every select value.
- R6: Select 1 gives a count enable in every cycle that is not halted.
- R7: Selects 2, 3, 4 and 5 give one-cycle enables with periods 8, 64, 256 and 1024. The first pulse comes in the N-th non-halted cycle after the counter was cleared.
- R8: Select 7 counts rising edges and select 6 counts falling edges of the timer's own pin, with one enable per edge and no division. The enable is high for one cycle, beginning at the second clock edge after the pin changes.
- R9: Writing 0 to the synchronization bit clears the reset bit, and two timers with equal tap selects then give their first pulses in the same cycle.
- R10: Select 0 gives no count enables.
- R11: `cap_src` follows register bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| cs0 | input | 3 | Clock-source select, timer 0 |
| cs1 | input | 3 | Clock-source select, timer 1 |
| ext0 | input | 1 | External clock pin, timer 0 |
| ext1 | input | 1 | External clock pin, timer 1 |
| ce0 | output | 1 | Count enable, timer 0 |
| ce1 | output | 1 | Count enable, timer 1 |
| halted | output | 1 | Prescaler held in reset |
| cap_src | output | 1 | Capture-source select bit |
| ctrl_rd | output | 8 | Register read value |

## Verification
Directed cases cover the reset state, the readback of 0xFF, and a sticky halt followed by a synchronized release. After that release, both timers on the divide-by-8 tap must give their first pulse in the same cycle. A single-cycle reset while the divide-by-256 and divide-by-1024 taps are selected checks that the counter restarts from zero. Slow square waves on the pins count rising and falling edges separately and fix the two-cycle latency. A random phase then mixes select changes, pin toggles, and register writes with either value of the synchronization bit. Each cycle is compared with a cycle model built from the requirements, which shows up tap, polarity, and halt-gating errors.

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
  parameter int CNT_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [2:0] cs0,
  input  logic [2:0] cs1,
  input  logic       ext0,
  input  logic       ext1,
  output logic       ce0,
  output logic       ce1,
  output logic       halted,
  output logic       cap_src,
  output logic [7:0] ctrl_rd
);
  localparam int NCH = 2;

  logic             sync_mode, cap_sel, psr;
  logic [CNT_W-1:0] cnt;
  logic [NCH-1:0]   ext_in, ce_v;
  logic [2:0]       cs_in [NCH];

  assign ext_in   = {ext1, ext0};
  assign cs_in[0] = cs0;
  assign cs_in[1] = cs1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_mode <= 1'b0;
      cap_sel   <= 1'b0;
      psr       <= 1'b0;
    end else if (wr_en) begin
      sync_mode <= wr_data[7];
      cap_sel   <= wr_data[6];
      psr       <= wr_data[0];
    end else if (!sync_mode) begin
      psr <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (psr) cnt <= '0;
    else          cnt <= cnt + 1'b1;

  function automatic logic tap(input logic [CNT_W-1:0] c, input int b);
    logic [CNT_W-1:0] m;
    m = (CNT_W'(1) << b) - CNT_W'(1);
    return (c & m) == m;
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic s1, s2, s3, sel;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) {s3, s2, s1} <= 3'b000;
      else        {s3, s2, s1} <= {s2, s1, ext_in[g]};

    always_comb
      case (cs_in[g])
        3'd1:    sel = 1'b1;
        3'd2:    sel = tap(cnt, 3);
        3'd3:    sel = tap(cnt, 6);
        3'd4:    sel = tap(cnt, 8);
        3'd5:    sel = tap(cnt, 10);
        3'd6:    sel = s3 & ~s2;
        3'd7:    sel = s2 & ~s3;
        default: sel = 1'b0;
      endcase

    assign ce_v[g] = sel & ~psr;

    p_div1_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_in[g] == 3'd1 && !halted) |-> ce_v[g]);
    p_ext_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_in[g][2:1] == 2'b11 && ce_v[g]) |=> (!ce_v[g] || !$stable(cs_in[g])));
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_in[g] == 3'd0) |-> !ce_v[g]);
  end

  assign ce0     = ce_v[0];
  assign ce1     = ce_v[1];
  assign halted  = psr;
  assign cap_src = cap_sel;
  assign ctrl_rd = {sync_mode, cap_sel, 5'b00000, psr};

  p_halt_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (ce0 == 1'b0 && ce1 == 1'b0));
  p_self_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !wr_en) |=> !halted);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !wr_en) |=> $stable(halted));
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (cnt == '0));
  p_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[5:1] == 5'b00000);
endmodule

// File: tb/test_shared_prescaler.sv
module test_shared_prescaler;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, ext0 = 0, ext1 = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] cs0 = 0, cs1 = 0;
  logic ce0, ce1, halted, cap_src;
  logic [7:0] ctrl_rd;
  int checks = 0, fails = 0;

  shared_prescaler i_shared_prescaler (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cs0(cs0), .cs1(cs1), .ext0(ext0), .ext1(ext1),
    .ce0(ce0), .ce1(ce1), .halted(halted), .cap_src(cap_src), .ctrl_rd(ctrl_rd));

  always #(CLK_PERIOD/2) clk = ~clk;

  // cycle model built from the requirements
  logic m_tsm, m_cap, m_psr, n_psr;
  logic [9:0] m_cnt;
  logic [1:0] m1, m2, m3;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_tsm = 0; m_cap = 0; m_psr = 0; m_cnt = 0; m1 = 0; m2 = 0; m3 = 0;
    end else begin
      n_psr = wr_en ? wr_data[0] : (m_tsm ? m_psr : 1'b0);
      m_cnt = m_psr ? 10'd0 : m_cnt + 10'd1;
      if (wr_en) begin m_tsm = wr_data[7]; m_cap = wr_data[6]; end
      m_psr = n_psr;
      m3 = m2; m2 = m1; m1 = {ext1, ext0};
    end
  end

  function automatic logic exp_ce(input logic [2:0] cs, input int g);
    logic r;
    case (cs)
      3'd1: r = 1;
      3'd2: r = (m_cnt & 10'd7) == 10'd7;
      3'd3: r = (m_cnt & 10'd63) == 10'd63;
      3'd4: r = (m_cnt & 10'd255) == 10'd255;
      3'd5: r = m_cnt == 10'd1023;
      3'd6: r = m3[g] & ~m2[g];
      3'd7: r = m2[g] & ~m3[g];
      default: r = 0;
    endcase
    return r & ~m_psr;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 ctrl", ctrl_rd, 8'h00);
    check("R1 halted", halted, 0);
    check("R1 cap_src", cap_src, 0);
    check("R10 stop", {ce1, ce0}, 2'b00);

    // R2 / R4 / R5: sticky halt
    cs0 = 3'd1; cs1 = 3'd1;
    wr(8'hFF);
    check("R2 readback", ctrl_rd, 8'hC1);
    for (int k = 0; k < 20; k++) begin
      if (k % 5 == 0) begin
        check("R4 held", halted, 1);
        check("R5 no ce", {ce1, ce0}, 2'b00);
      end
      @(negedge clk);
    end

    // R9 / R7: synchronized release, both on divide by 8
    cs0 = 3'd2; cs1 = 3'd2;
    wr(8'h00);
    check("R9 released", halted, 0);
    for (int k = 1; k <= 24; k++) begin
      check("R9 equal ce", {1'b0, ce1}, {1'b0, ce0});
      check("R7 div8", ce0, (k % 8) == 0);
      @(negedge clk);
    end

    // R3 / R7: single-cycle reset, long taps
    cs0 = 3'd5; cs1 = 3'd4;
    wr(8'h01);
    check("R3 one-cycle halt", halted, 1);
    @(negedge clk);
    check("R3 self clear", halted, 0);
    check("R3 ctrl", ctrl_rd, 8'h00);
    n = 0;
    for (int k = 2; k <= 1025; k++) begin
      if (ce0) n++;
      if (k == 257)  check("R7 div256 first", ce1, 1);
      if (k == 1025) check("R7 div1024 first", ce0, 1);
      if (k == 513)  check("R7 div256 second", ce1, 1);
      @(negedge clk);
    end
    check("R7 div1024 count", n, 1);

    // R6
    cs0 = 3'd1; cs1 = 3'd0;
    n = 0;
    for (int k = 0; k < 50; k++) begin #1; if (ce0 && !ce1) n++; @(negedge clk); end
    check("R6/R10 div1", n, 50);

    // R8: latency and per-edge counting
    cs0 = 3'd7; cs1 = 3'd6;
    repeat (4) @(negedge clk);
    ext0 = 1;
    #1 check("R8 lat0", ce0, 0);
    @(negedge clk); check("R8 lat1", ce0, 0);
    @(negedge clk); check("R8 lat2", ce0, 1);
    @(negedge clk); check("R8 lat3", ce0, 0);
    ext0 = 0;
    repeat (4) @(negedge clk);
    begin
      int nr = 0, nf = 0;
      for (int k = 0; k < 120; k++) begin
        if (k % 3 == 0 && k < 100) begin ext0 = ~ext0; ext1 = ~ext1; end
        #1;
        if (ce0) nr++;
        if (ce1) nf++;
        @(negedge clk);
      end
      // 34 toggles starting low: 17 rising, 17 falling (ext1 starts low too)
      check("R8 rising count", nr, 17);
      check("R8 falling count", nf, 17);
    end

    // R11
    wr(8'h40);
    check("R11 cap_src", cap_src, 1);
    check("R2 ctrl 40", ctrl_rd, 8'h40);

    // random phase against model
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 16 == 0) cs0 = 3'($urandom);
      if ($urandom % 16 == 0) cs1 = 3'($urandom);
      if ($urandom % 3 == 0) ext0 = ~ext0;
      if ($urandom % 4 == 0) ext1 = ~ext1;
      wr_en = ($urandom % 25 == 0);
      wr_data = 8'($urandom);
      #1;
      check("R5/R7/R8 ce0", ce0, exp_ce(cs0, 0));
      check("R5/R7/R8 ce1", ce1, exp_ce(cs1, 1));
      check("R3/R4 halted", halted, m_psr);
      check("R2/R11 ctrl", ctrl_rd, {m_tsm, m_cap, 5'b0, m_psr});
      @(negedge clk);
    end
    wr_en = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule